// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM Timer

The block generates four pulse-width-modulated signals from one shared up-counter. The counter is clocked through a shared clock divider. Each channel compares the live counter value with its own threshold. The channel's raw level is high while the counter is below that threshold. That raw level then drives two pins: a true output and a complementary output. Each pin has its own enable and its own inversion control, and a global output gate sits in front of all eight pins.

Software programs the block through a simple write port. The divider value, the period limit and the thresholds are written into holding registers. They reach the working copies only at an update event. An update event happens either when the counter wraps or when software writes the force-update strobe. The period limit can be taken out of this double buffering by clearing its buffer-enable bit. Without that bit, a new period limit applies at once.

Register map (word address on `wr_addr_i`):

| Addr | Content |
|------|---------|
| 0 | control: bit0 counter run, bit1 period-limit buffer enable, bit2 global output gate |
| 1 | bit0 = 1 forces an update event |
| 2 | divider value (held until update) |
| 3 | period limit (buffered or direct) |
| 4..7 | threshold of channel 0..3 (held until update) |
| 8 | channel control: 4 bits per channel at offset 4*ch |

Within each 4-bit channel group, bit0 enables the true pin, bit1 inverts it, bit2 enables the complementary pin and bit3 inverts it.

Top module: `pwm_timer4`

## Requirements
- R1: While the run bit is set, the counter advances by one every (divider + 1) clock cycles.
- R2: The counter counts 0 up to the live period limit and then returns to 0, so one period is limit + 1 counter ticks.
- R3: With the buffer-enable bit set, a period-limit write takes effect only at the next update event. With the bit clear, the write takes effect in the cycle after the write.
- R4: Writing 1 to bit0 at address 1 resets the counter and the divider phase in the next cycle and loads the divider, period-limit and threshold working copies. This works whether or not the counter is running.
- R5: Divider and threshold writes change nothing until an update event; a counter wrap is one such event.
- R6: Channel ch is controlled by bits [4*ch+3:4*ch] of address 8 (bit0 true enable, bit1 true invert, bit2 complementary enable, bit3 complementary invert). A channel whose group is clear does not follow the counter.
- R7: The raw channel level is high while counter < threshold. With no inversion, the true pin equals the raw level.
- R8: An invert bit flips its pin.
- R9: A threshold of 0 keeps the raw level low for the whole period. A threshold above the period limit keeps it high for the whole period.
- R10: The complementary pin carries the inverse of the raw level, then its own invert bit is applied. No dead time is inserted.
- R11: When a pin's enable is clear or the global output gate is clear, the pin sits at its inactive level, which equals its invert bit. After reset all pins are 0.
- R12: With the run bit clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 4 | register word address |
| wr_data_i | input | 32 | register write data |
| cnt_o | output | 16 | live counter value |
| pwm_o | output | 4 | true channel pins |
| pwm_n_o | output | 4 | complementary channel pins |

## Verification
The bench looks for four kinds of fault.

- A period limit written while buffering is on must not apply mid-period. A design that applied it early would wrap near the new limit instead of the old one. The bench checks the count at a point between the two limits, and again after the wrap, when the new limit has become live.
- A threshold must not move before a wrap. A design that applied it early would flip a channel in the middle of a period.
- The inactive level must include the invert bit. A design that drove gated pins to 0 instead of to their invert level would show up here.
- A forced update must reset the counter and load a new divider. A design that did not would keep the old count or the old step rate.

The bench also sweeps the threshold extremes over a full period and checks the complementary pin with its own inversion.

// File: rtl/pwm_timer4_pkg.sv
package pwm_timer4_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_UPD  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'd2;
  localparam logic [ADDR_W-1:0] A_ARR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CHEN = 4'd8;

  // control bit positions
  localparam int C_RUN  = 0;
  localparam int C_BUF  = 1;
  localparam int C_GATE = 2;

  // per-channel group, lsb first: oe, op, ne, np
  typedef struct packed {
    logic np;
    logic ne;
    logic op;
    logic oe;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             force_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] pcnt_q;

  assign tick_o = run_i && !force_i && (pcnt_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= '0;
    else if (force_i) pcnt_q <= '0;
    else if (run_i)   pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
  end

  p_phase_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= psc_i);
  p_phase_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> pcnt_q == '0);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // >= so a limit lowered below the count still wraps on the next tick
  assign wrap_o = tick_i && (cnt_q >= arr_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (force_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !force_i && cnt_q < arr_i |=> cnt_q == $past(cnt_q) + 1'b1);
  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !force_i && cnt_q >= arr_i |=> cnt_q == '0);
  p_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> cnt_q == '0);
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !force_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer4_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  ch_cfg_t          cfg_i,
  input  logic             gate_i,
  output logic             out_o,
  output logic             out_n_o
);
  logic ref_lvl;

  assign ref_lvl = cnt_i < cmp_i;
  assign out_o   = (gate_i && cfg_i.oe) ? (ref_lvl ^ cfg_i.op) : cfg_i.op;
  assign out_n_o = (gate_i && cfg_i.ne) ? (!ref_lvl ^ cfg_i.np) : cfg_i.np;

  p_compl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i && cfg_i.oe && cfg_i.ne |-> ((out_o ^ cfg_i.op) != (out_n_o ^ cfg_i.np)));
  p_zero_cmp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i && cfg_i.oe && cmp_i == '0 |-> out_o == cfg_i.op);
endmodule

// File: rtl/pwm_timer4.sv
module pwm_timer4
  import pwm_timer4_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int N_CH  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [N_CH-1:0]       pwm_o,
  output logic [N_CH-1:0]       pwm_n_o
);
  localparam int CHEN_W = 4 * N_CH;

  logic             run_q, buf_q, gate_q;
  logic [PSC_W-1:0] psc_pre_q, psc_sh_q;
  logic [CNT_W-1:0] arr_pre_q, arr_sh_q;
  logic [CNT_W-1:0] cmp_pre_q [N_CH];
  logic [CNT_W-1:0] cmp_sh_q  [N_CH];
  logic [CHEN_W-1:0] chen_q;

  logic wr_ctrl, wr_psc, wr_arr, wr_chen, force_upd;
  logic tick, wrap, upd;
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl   = wr_en_i && wr_addr_i == A_CTRL;
  assign wr_psc    = wr_en_i && wr_addr_i == A_PSC;
  assign wr_arr    = wr_en_i && wr_addr_i == A_ARR;
  assign wr_chen   = wr_en_i && wr_addr_i == A_CHEN;
  assign force_upd = wr_en_i && wr_addr_i == A_UPD && wr_data_i[0];
  assign upd       = force_upd || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      buf_q  <= 1'b0;
      gate_q <= 1'b0;
      chen_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wr_data_i[C_RUN];
        buf_q  <= wr_data_i[C_BUF];
        gate_q <= wr_data_i[C_GATE];
      end
      if (wr_chen) chen_q <= wr_data_i[CHEN_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_pre_q <= '0;
      psc_sh_q  <= '0;
    end else begin
      if (wr_psc) psc_pre_q <= wr_data_i[PSC_W-1:0];
      if (upd)    psc_sh_q  <= psc_pre_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_pre_q <= '1;
      arr_sh_q  <= '1;
    end else begin
      if (wr_arr) arr_pre_q <= wr_data_i[CNT_W-1:0];
      if (wr_arr && !buf_q) arr_sh_q <= wr_data_i[CNT_W-1:0];
      else if (upd)         arr_sh_q <= arr_pre_q;
    end
  end

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .force_i (force_upd),
    .psc_i   (psc_sh_q),
    .tick_o  (tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .tick_i  (tick),
    .force_i (force_upd),
    .arr_i   (arr_sh_q),
    .cnt_o   (cnt),
    .wrap_o  (wrap)
  );

  assign cnt_o = cnt;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic wr_cmp;
    assign wr_cmp = wr_en_i && wr_addr_i == A_CMP0 + ADDR_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_pre_q[g] <= '0;
        cmp_sh_q[g]  <= '0;
      end else begin
        if (wr_cmp) cmp_pre_q[g] <= wr_data_i[CNT_W-1:0];
        if (upd)    cmp_sh_q[g]  <= cmp_pre_q[g];
      end
    end

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_i   (cnt),
      .cmp_i   (cmp_sh_q[g]),
      .cfg_i   (ch_cfg_t'(chen_q[4*g +: 4])),
      .gate_i  (gate_q),
      .out_o   (pwm_o[g]),
      .out_n_o (pwm_n_o[g])
    );

    p_cmp_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd |=> $stable(cmp_sh_q[g]));
  end

  p_psc_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(psc_sh_q));
  p_arr_buffered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_q && !upd |=> $stable(arr_sh_q));

  initial begin
    assert (N_CH >= 1 && N_CH <= 4) else $error("N_CH out of range");
  end
endmodule

// File: tb/pwm_timer4_tb.sv
module pwm_timer4_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] cnt;
  logic [3:0]  pwm, pwm_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer4 u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .cnt_o     (cnt),
    .pwm_o     (pwm),
    .pwm_n_o   (pwm_n)
  );

  typedef struct packed {
    logic [15:0] psc;
    logic [15:0] arr;
    logic [15:0] cmp;
    logic [15:0] pol;
    logic [15:0] t;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{16'd0, 16'd9, 16'd4, 16'd0, 16'd3},
    '{16'd0, 16'd9, 16'd4, 16'd0, 16'd7},
    '{16'd2, 16'd9, 16'd5, 16'd0, 16'd14},
    '{16'd2, 16'd9, 16'd5, 16'd1, 16'd17},
    '{16'd1, 16'd4, 16'd2, 16'd0, 16'd13},
    '{16'd3, 16'd7, 16'd0, 16'd0, 16'd10},
    '{16'd0, 16'd5, 16'd6, 16'd0, 16'd5},
    '{16'd4, 16'd3, 16'd2, 16'd1, 16'd23}
  };

  function automatic int exp_cnt(int t, int psc, int arr);
    return (t / (psc + 1)) % (arr + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int c;
    wait_n(2);
    // R11 reset state
    check("R11 reset cnt", cnt, 0);
    check("R11 reset pwm", pwm, 0);
    check("R11 reset pwm_n", pwm_n, 0);
    rst_n = 1'b1;
    wait_n(1);

    // table walk: R1 R2 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      int e;
      wr(4'd2, VEC[v].psc);
      wr(4'd3, VEC[v].arr);
      wr(4'd4, VEC[v].cmp);
      wr(4'd8, {30'd0, VEC[v].pol[0], 1'b1});
      wr(4'd0, 32'h7);
      wr(4'd1, 32'h1);
      wait_n(VEC[v].t);
      e = exp_cnt(VEC[v].t, VEC[v].psc, VEC[v].arr);
      check("R1 R2 count", cnt, e);
      check("R7 R8 R9 pwm0", pwm[0], int'((e < VEC[v].cmp) ^ VEC[v].pol[0]));
    end

    // R12 hold, then R4 force while stopped
    wr(4'd0, 32'h4);
    c = cnt;
    wait_n(5);
    check("R12 hold", cnt, c);
    wr(4'd1, 32'h1);
    check("R4 force stopped", cnt, 0);

    // R3 buffered limit
    wr(4'd2, 0); wr(4'd3, 9); wr(4'd0, 32'h7); wr(4'd1, 1);
    wr(4'd3, 3);
    wait_n(5);
    check("R3 old limit live", cnt, 6);
    wait_n(7);
    check("R3 new limit top", cnt, 3);
    wait_n(1);
    check("R3 new limit wrap", cnt, 0);

    // R3 direct limit
    wr(4'd0, 32'h5); wr(4'd3, 9); wr(4'd1, 1);
    wr(4'd3, 2);
    wait_n(2);
    check("R3 direct limit", cnt, 0);

    // R4 force loads divider, R5 divider held
    wr(4'd0, 32'h7); wr(4'd2, 0); wr(4'd3, 9); wr(4'd1, 1);
    wait_n(4);
    wr(4'd2, 1);
    wait_n(1);
    check("R5 divider held", cnt, 6);
    wr(4'd1, 1);
    check("R4 force reset", cnt, 0);
    wait_n(2);
    check("R4 new divider", cnt, 1);
    wait_n(1);
    check("R4 new divider step", cnt, 1);

    // R5 threshold held until wrap, R6 channel 2 only
    wr(4'd2, 0); wr(4'd3, 9); wr(4'd6, 4); wr(4'd8, 32'h100); wr(4'd1, 1);
    wr(4'd6, 8);
    wait_n(4);
    check("R5 old threshold", pwm[2], 0);
    check("R6 ch0 idle", pwm[0], 0);
    wait_n(11);
    check("R5 new threshold", pwm[2], 1);

    // R10 complementary on ch1
    wr(4'd5, 3); wr(4'd8, 32'h50); wr(4'd1, 1);
    wait_n(1);
    check("R10 true high", pwm[1], 1);
    check("R10 compl low", pwm_n[1], 0);
    wait_n(4);
    check("R10 true low", pwm[1], 0);
    check("R10 compl high", pwm_n[1], 1);
    wr(4'd8, 32'hD0);
    check("R8 compl inverted", pwm_n[1], 0);

    // R11 gate and enable off on ch3
    wr(4'd7, 5); wr(4'd8, 32'h7000); wr(4'd0, 32'h3); wr(4'd1, 1);
    check("R11 gate off true", pwm[3], 1);
    check("R11 gate off compl", pwm_n[3], 0);
    wr(4'd0, 32'h7);
    check("R8 gate on inverted", pwm[3], 0);
    wr(4'd8, 32'h2000);
    check("R11 enable off", pwm[3], 1);

    // R9 extremes over one period
    wr(4'd4, 0); wr(4'd5, 10); wr(4'd8, 32'h11); wr(4'd1, 1);
    for (int i = 0; i < 10; i++) begin
      check("R9 zero threshold", pwm[0], 0);
      check("R9 above limit", pwm[1], 1);
      wait_n(1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule